// File: doc/BRIEF.md
# Mixed-Width Configuration Register File

This block holds the device-specific part of a configuration space: two 16-bit channel timing registers, an 8-bit secondary-device timing byte, an 8-bit ultra-DMA control byte, a 16-bit ultra-DMA timing register and a 16-bit interface configuration register. A requester presents one access per cycle on a single request port. Each access carries an offset, a size (byte, halfword or word), a write flag and write data. Each register accepts only its own set of size/offset pairs. Any other access is refused.

An offset below the start of the device-specific region is not decoded locally. It is passed straight to a generic-header port and produces no local response. Local accesses answer one cycle later with a response strobe, an error flag and read data. Partial writes into a 16-bit register touch only the byte lane they address. Data is little-endian, and byte lane 0 is the least significant byte.

Top module: `pcfg_regfile`

## Requirements
- R1: When the request offset is below `DEV_START` (0x40), the request is copied the same cycle onto the `hdr_req_*` outputs with `hdr_req_valid` high. No local response follows in the next cycle.
- R2: After reset, both channel timing registers read 0x8000 (bit 15 is the decode-enable bit). The ultra-DMA timing, interface configuration, secondary timing and ultra-DMA control registers read 0.
- R3: A halfword read or write (`req_size`=1) at the base offset of either channel timing register (0x40, 0x42), the ultra-DMA timing register (0x4A) or the interface configuration register (0x54) is accepted. A write replaces all 16 bits with `req_wdata[15:0]`. A read returns the whole register.
- R4: A byte read (`req_size`=0) at base+1 of a channel timing register (0x41, 0x43) returns that register's bits 15:8 on `rsp_rdata[7:0]`, with `rsp_rdata[15:8]` = 0.
- R5: The secondary timing byte (0x44) and the ultra-DMA control byte (0x48) accept only byte reads and writes. Byte write data is taken from `req_wdata[7:0]`. A halfword access at either offset is refused.
- R6: A byte write to the interface configuration register at 0x54 loads bits 7:0 from `req_wdata[7:0]`. A byte write at 0x55 loads bits 15:8 from `req_wdata[7:0]`. The other byte is kept.
- R7: A byte read of the interface configuration register returns bits 7:0 at 0x54 and bits 15:8 at 0x55, on `rsp_rdata[7:0]`.
- R8: Any local access with `req_size`=2 (word) or 3 (reserved) is refused.
- R9: Every local size/offset pair not granted in R3 to R7 is refused. This includes byte writes at 0x41 and 0x43, byte reads at 0x40, 0x42 and 0x4A, and any unmapped offset. A refused access leaves every register unchanged.
- R10: Every local request produces `rsp_valid` exactly one cycle later. `rsp_err` is 1 for a refused access. `rsp_rdata` is 0 for writes and refused accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset in configuration space |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_wdata | input | 16 | Write data, lane 0 in bits 7:0 |
| rsp_valid | output | 1 | Local response strobe, one cycle after the request |
| rsp_err | output | 1 | Access refused |
| rsp_rdata | output | 16 | Read data |
| hdr_req_valid | output | 1 | Forwarded request to the generic header |
| hdr_req_write | output | 1 | Forwarded write flag |
| hdr_req_addr | output | ADDR_W | Forwarded offset |
| hdr_req_size | output | 2 | Forwarded size |
| hdr_req_wdata | output | 16 | Forwarded write data |

## Verification
The bench builds the block with its default offsets: region start 0x40, the registers at 0x40, 0x42, 0x44, 0x48, 0x4A and 0x54, and a timing reset value of 0x8000. Random offsets are drawn from 0x3C to 0x57. This range reaches the boundary into the forwarded region, both lanes of every 16-bit register, and the unmapped gaps between registers. All four size codes are mixed with reads and writes, so each refused pair can be followed by a read that shows the register was not changed.

// File: rtl/cfgrf_pkg.sv
package cfgrf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        TG_NONE = 3'd0,
        TG_TIM0 = 3'd1,
        TG_TIM1 = 3'd2,
        TG_UTIM = 3'd3,
        TG_IFC  = 3'd4,
        TG_SLV  = 3'd5,
        TG_UCTL = 3'd6
    } tgt_e;

    typedef struct packed {
        logic       local_hit;
        logic       ok;
        tgt_e       tgt;
        logic       hi_lane;
        logic [1:0] lane_we;
    } dec_t;

    typedef struct packed {
        logic        vld;
        logic        err;
        logic [15:0] rdata;
    } rsp_t;

endpackage

// File: rtl/cfgrf_decode.sv
module cfgrf_decode
    import cfgrf_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DEV_START = 8'h40,
    parameter logic [ADDR_W-1:0] TIM0_OFS  = 8'h40,
    parameter logic [ADDR_W-1:0] TIM1_OFS  = 8'h42,
    parameter logic [ADDR_W-1:0] SLV_OFS   = 8'h44,
    parameter logic [ADDR_W-1:0] UCTL_OFS  = 8'h48,
    parameter logic [ADDR_W-1:0] UTIM_OFS  = 8'h4A,
    parameter logic [ADDR_W-1:0] IFC_OFS   = 8'h54
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  logic              wr,
    output dec_t              dec
);

    localparam logic [ADDR_W-1:0] TIM0_HI = TIM0_OFS + 1'b1;
    localparam logic [ADDR_W-1:0] TIM1_HI = TIM1_OFS + 1'b1;
    localparam logic [ADDR_W-1:0] IFC_HI  = IFC_OFS + 1'b1;

    logic is_b;
    logic is_h;

    always_comb begin
        is_b = (size == SZ_BYTE);
        is_h = (size == SZ_HALF);
        dec = '0;
        dec.tgt = TG_NONE;
        dec.local_hit = (addr >= DEV_START);
        if (addr == TIM0_OFS) begin
            dec.tgt     = TG_TIM0;
            dec.ok      = is_h;
            dec.lane_we = {2{is_h & wr}};
        end else if (addr == TIM0_HI) begin
            dec.tgt     = TG_TIM0;
            dec.ok      = is_b & ~wr;
            dec.hi_lane = 1'b1;
        end else if (addr == TIM1_OFS) begin
            dec.tgt     = TG_TIM1;
            dec.ok      = is_h;
            dec.lane_we = {2{is_h & wr}};
        end else if (addr == TIM1_HI) begin
            dec.tgt     = TG_TIM1;
            dec.ok      = is_b & ~wr;
            dec.hi_lane = 1'b1;
        end else if (addr == SLV_OFS) begin
            dec.tgt     = TG_SLV;
            dec.ok      = is_b;
            dec.lane_we = {1'b0, is_b & wr};
        end else if (addr == UCTL_OFS) begin
            dec.tgt     = TG_UCTL;
            dec.ok      = is_b;
            dec.lane_we = {1'b0, is_b & wr};
        end else if (addr == UTIM_OFS) begin
            dec.tgt     = TG_UTIM;
            dec.ok      = is_h;
            dec.lane_we = {2{is_h & wr}};
        end else if (addr == IFC_OFS) begin
            dec.tgt     = TG_IFC;
            dec.ok      = is_b | is_h;
            dec.lane_we = wr ? (is_h ? 2'b11 : (is_b ? 2'b01 : 2'b00)) : 2'b00;
        end else if (addr == IFC_HI) begin
            dec.tgt     = TG_IFC;
            dec.ok      = is_b;
            dec.hi_lane = 1'b1;
            dec.lane_we = {is_b & wr, 1'b0};
        end
        if (!dec.local_hit) begin
            dec.ok      = 1'b0;
            dec.tgt     = TG_NONE;
            dec.hi_lane = 1'b0;
            dec.lane_we = 2'b00;
        end
    end

endmodule

// File: rtl/cfgrf_lane_reg.sv
module cfgrf_lane_reg #(
    parameter int                 LANES   = 2,
    parameter logic [LANES*8-1:0] RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LANES-1:0]   we,
    input  logic [LANES*8-1:0] wdata,
    output logic [LANES*8-1:0] q
);

    logic [LANES*8-1:0] data_d;
    logic [LANES*8-1:0] data_q;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            always_comb begin
                data_d[g*8 +: 8] = we[g] ? wdata[g*8 +: 8] : data_q[g*8 +: 8];
            end

            // R6: a lane without its enable keeps its byte
            assert_lane_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
                !we[g] |=> $stable(data_q[g*8 +: 8]));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= RST_VAL;
        end else begin
            data_q <= data_d;
        end
    end

    assign q = data_q;

endmodule

// File: rtl/pcfg_regfile.sv
module pcfg_regfile
    import cfgrf_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] DEV_START = 8'h40,
    parameter logic [ADDR_W-1:0] TIM0_OFS  = 8'h40,
    parameter logic [ADDR_W-1:0] TIM1_OFS  = 8'h42,
    parameter logic [ADDR_W-1:0] SLV_OFS   = 8'h44,
    parameter logic [ADDR_W-1:0] UCTL_OFS  = 8'h48,
    parameter logic [ADDR_W-1:0] UTIM_OFS  = 8'h4A,
    parameter logic [ADDR_W-1:0] IFC_OFS   = 8'h54,
    parameter logic [15:0]       TIM_RST   = 16'h8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [15:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [15:0]       rsp_rdata,
    output logic              hdr_req_valid,
    output logic              hdr_req_write,
    output logic [ADDR_W-1:0] hdr_req_addr,
    output logic [1:0]        hdr_req_size,
    output logic [15:0]       hdr_req_wdata
);

    localparam int HALF_W = 16;
    localparam int BYTE_W = HALF_W / 2;
    localparam int N_WIDE = 4;
    localparam tgt_e WIDE_TGT [N_WIDE] = '{TG_TIM0, TG_TIM1, TG_UTIM, TG_IFC};
    localparam logic [HALF_W-1:0] WIDE_RST [N_WIDE] = '{TIM_RST, TIM_RST, '0, '0};

    dec_t              dec;
    logic              local_req;
    logic              acc_ok;
    logic [HALF_W-1:0] lane_wdata;
    logic [1:0]        we_w   [N_WIDE];
    logic [HALF_W-1:0] wide_q [N_WIDE];
    logic              we_slv;
    logic              we_uctl;
    logic [BYTE_W-1:0] slv_q;
    logic [BYTE_W-1:0] uctl_q;
    logic [HALF_W-1:0] full_rd;
    logic [HALF_W-1:0] shaped_rd;
    rsp_t              rsp_d;
    rsp_t              rsp_q;

    cfgrf_decode #(
        .ADDR_W   (ADDR_W),
        .DEV_START(DEV_START),
        .TIM0_OFS (TIM0_OFS),
        .TIM1_OFS (TIM1_OFS),
        .SLV_OFS  (SLV_OFS),
        .UCTL_OFS (UCTL_OFS),
        .UTIM_OFS (UTIM_OFS),
        .IFC_OFS  (IFC_OFS)
    ) u_decode (
        .addr(req_addr),
        .size(acc_size_e'(req_size)),
        .wr  (req_write),
        .dec (dec)
    );

    // forwarding toward the generic header
    always_comb begin
        hdr_req_valid = req_valid & ~dec.local_hit;
        hdr_req_write = req_write;
        hdr_req_addr  = req_addr;
        hdr_req_size  = req_size;
        hdr_req_wdata = req_wdata;
    end

    always_comb begin
        local_req  = req_valid & dec.local_hit;
        acc_ok     = local_req & dec.ok;
        lane_wdata = {(req_size == SZ_BYTE) ? req_wdata[7:0] : req_wdata[15:8],
                      req_wdata[7:0]};
        we_slv     = acc_ok & req_write & (dec.tgt == TG_SLV) & dec.lane_we[0];
        we_uctl    = acc_ok & req_write & (dec.tgt == TG_UCTL) & dec.lane_we[0];
    end

    generate
        for (genvar w = 0; w < N_WIDE; w++) begin : g_wide
            always_comb begin
                we_w[w] = (acc_ok && req_write && dec.tgt == WIDE_TGT[w]) ? dec.lane_we : 2'b00;
            end

            cfgrf_lane_reg #(
                .LANES  (2),
                .RST_VAL(WIDE_RST[w])
            ) u_reg (
                .clk  (clk),
                .rst_n(rst_n),
                .we   (we_w[w]),
                .wdata(lane_wdata),
                .q    (wide_q[w])
            );
        end
    endgenerate

    cfgrf_lane_reg #(
        .LANES  (1),
        .RST_VAL(8'h00)
    ) u_slv (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we_slv),
        .wdata(req_wdata[7:0]),
        .q    (slv_q)
    );

    cfgrf_lane_reg #(
        .LANES  (1),
        .RST_VAL(8'h00)
    ) u_uctl (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (we_uctl),
        .wdata(req_wdata[7:0]),
        .q    (uctl_q)
    );

    // read path and next response
    always_comb begin
        case (dec.tgt)
            TG_TIM0: full_rd = wide_q[0];
            TG_TIM1: full_rd = wide_q[1];
            TG_UTIM: full_rd = wide_q[2];
            TG_IFC:  full_rd = wide_q[3];
            TG_SLV:  full_rd = {{BYTE_W{1'b0}}, slv_q};
            TG_UCTL: full_rd = {{BYTE_W{1'b0}}, uctl_q};
            default: full_rd = '0;
        endcase
        if (dec.hi_lane) begin
            shaped_rd = {{BYTE_W{1'b0}}, full_rd[15:8]};
        end else if (req_size == SZ_BYTE) begin
            shaped_rd = {{BYTE_W{1'b0}}, full_rd[7:0]};
        end else begin
            shaped_rd = full_rd;
        end

        rsp_d       = '0;
        rsp_d.vld   = local_req;
        rsp_d.err   = local_req & ~dec.ok;
        rsp_d.rdata = (acc_ok && !req_write) ? shaped_rd : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid = rsp_q.vld;
    assign rsp_err   = rsp_q.err;
    assign rsp_rdata = rsp_q.rdata;

    assert_fwd_no_rsp_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr < DEV_START) |=> !rsp_valid);

    assert_slv_half_refused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr == SLV_OFS && req_size == 2'd1) |=> rsp_err);

    assert_word_refused_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= DEV_START && req_size == 2'd2) |=> (rsp_valid && rsp_err));

    assert_err_keeps_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(wide_q[0]) && $stable(wide_q[1]) && $stable(wide_q[2])
                     && $stable(wide_q[3]) && $stable(slv_q) && $stable(uctl_q)));

    assert_rsp_after_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_addr >= DEV_START) |=> rsp_valid);

    assert_err_no_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == 16'h0000));

endmodule

// File: tb/pcfg_regfile_tb_top.sv
module pcfg_regfile_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [15:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [15:0] rsp_rdata;
    logic        hdr_req_valid;
    logic        hdr_req_write;
    logic [7:0]  hdr_req_addr;
    logic [1:0]  hdr_req_size;
    logic [15:0] hdr_req_wdata;

    int total = 0;
    int bad = 0;
    logic [15:0] m [6];   // 0 tim0, 1 tim1, 2 utim, 3 ifc, 4 slv, 5 uctl

    always #5 clk = ~clk;

    pcfg_regfile dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .hdr_req_valid(hdr_req_valid), .hdr_req_write(hdr_req_write),
        .hdr_req_addr(hdr_req_addr), .hdr_req_size(hdr_req_size),
        .hdr_req_wdata(hdr_req_wdata)
    );

    task automatic check(input bit cond, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // reference behaviour from the requirements
    task automatic model(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                         input logic [15:0] wd, output bit ok, output logic [15:0] rd);
        int i;
        bit hi, b, h;
        ok = 0; rd = '0; hi = 0; i = 0;
        b = (sz == 2'd0);
        h = (sz == 2'd1);
        case (a)
            8'h40: begin i = 0; ok = h; end
            8'h41: begin i = 0; ok = b && !wr; hi = 1; end
            8'h42: begin i = 1; ok = h; end
            8'h43: begin i = 1; ok = b && !wr; hi = 1; end
            8'h44: begin i = 4; ok = b; end
            8'h48: begin i = 5; ok = b; end
            8'h4A: begin i = 2; ok = h; end
            8'h54: begin i = 3; ok = b || h; end
            8'h55: begin i = 3; ok = b; hi = 1; end
            default: ok = 0;
        endcase
        if (!ok) return;
        if (wr) begin
            if (h) m[i] = wd;
            else if (hi) m[i][15:8] = wd[7:0];
            else m[i][7:0] = wd[7:0];
        end else begin
            rd = hi ? {8'h00, m[i][15:8]} : (b ? {8'h00, m[i][7:0]} : m[i]);
        end
    endtask

    function automatic string tag_of(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                                     input bit ok);
        if (a < 8'h40) return "R1";
        if (sz >= 2'd2) return "R8";
        if (a == 8'h44 || a == 8'h48) return "R5";
        if (!ok) return "R9";
        if (a == 8'h41 || a == 8'h43) return "R4";
        if (sz == 2'd0 && (a == 8'h54 || a == 8'h55)) return wr ? "R6" : "R7";
        return "R3";
    endfunction

    // one request, driven at a falling edge, response checked at the next one
    task automatic do_req(input bit wr, input logic [7:0] a, input logic [1:0] sz,
                          input logic [15:0] wd, input string force_tag);
        bit ok, loc;
        logic [15:0] er;
        string t;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
        loc = (a >= 8'h40);
        ok = 0; er = '0;
        #1;
        if (loc) model(wr, a, sz, wd, ok, er);
        t = (force_tag != "") ? force_tag : tag_of(wr, a, sz, ok);
        if (!loc) begin
            check(hdr_req_valid && hdr_req_addr == a && hdr_req_write == wr
                  && hdr_req_size == sz && hdr_req_wdata == wd, "R1 forward",
                  {hdr_req_valid, 7'd0, hdr_req_addr, hdr_req_wdata},
                  {1'b1, 7'd0, a, wd});
        end else begin
            check(!hdr_req_valid, "R1 no forward", {31'd0, hdr_req_valid}, 32'd0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        check(rsp_valid == loc, "R10 rsp_valid", {31'd0, rsp_valid}, {31'd0, loc});
        if (loc) begin
            check(rsp_err == !ok && rsp_rdata == er, t,
                  {15'd0, rsp_err, rsp_rdata}, {15'd0, !ok, er});
        end
    endtask

    initial begin
        void'($urandom(32'd2024));
        m[0] = 16'h8000; m[1] = 16'h8000;
        m[2] = '0; m[3] = '0; m[4] = '0; m[5] = '0;
        repeat (3) @(negedge clk);
        check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R2 idle in reset",
              {30'd0, rsp_valid, rsp_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 reset values
        do_req(0, 8'h40, 2'd1, 0, "R2");
        do_req(0, 8'h42, 2'd1, 0, "R2");
        do_req(0, 8'h4A, 2'd1, 0, "R2");
        do_req(0, 8'h54, 2'd1, 0, "R2");
        do_req(0, 8'h44, 2'd0, 0, "R2");
        do_req(0, 8'h48, 2'd0, 0, "R2");
        // R3 / R4 halfword write then byte read of upper lane
        do_req(1, 8'h40, 2'd1, 16'hA5C3, "");
        do_req(0, 8'h40, 2'd1, 0, "");
        do_req(0, 8'h41, 2'd0, 0, "");
        // R9 byte write at upper timing offset refused, contents kept
        do_req(1, 8'h41, 2'd0, 16'h0077, "");
        do_req(0, 8'h40, 2'd1, 0, "R9 kept");
        do_req(0, 8'h40, 2'd0, 0, "");
        // R6 / R7 lane writes on the interface configuration register
        do_req(1, 8'h54, 2'd0, 16'hFF11, "");
        do_req(1, 8'h55, 2'd0, 16'hEE22, "");
        do_req(0, 8'h54, 2'd1, 0, "R6 merged");
        do_req(0, 8'h55, 2'd0, 0, "");
        do_req(0, 8'h54, 2'd0, 0, "");
        // R5 narrow registers
        do_req(1, 8'h44, 2'd0, 16'h1234, "");
        do_req(1, 8'h44, 2'd1, 16'h5678, "");
        do_req(0, 8'h44, 2'd0, 0, "R5 kept");
        do_req(1, 8'h48, 2'd0, 16'h00C7, "");
        do_req(0, 8'h48, 2'd1, 0, "");
        // R8 word and reserved sizes
        do_req(1, 8'h42, 2'd2, 16'hDEAD, "");
        do_req(0, 8'h54, 2'd3, 0, "");
        do_req(0, 8'h42, 2'd1, 0, "R8 kept");
        // R1 forwarded accesses, no local response
        do_req(1, 8'h10, 2'd1, 16'h4321, "");
        do_req(0, 8'h3F, 2'd2, 0, "");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [7:0] a;
            a = 8'h3C + 8'($urandom % 28);
            do_req(1'($urandom % 2), a, 2'($urandom % 4), 16'($urandom), "");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule